// File: doc/BRIEF.md
# Drive Seek Tracker with Interrupt Sense

This block follows up to four disk drives while their heads travel to a new cylinder, and answers the controller's "which drive has finished moving" query. A seek or a recalibrate is issued on one drive. The drive's busy bit in the main status byte goes high, and its head advances one cylinder per step period. The step period is a scaled copy of the programmed step-rate value. When the head is on the wanted cylinder, the drive holds a pending completion.

A sense query reports the lowest-numbered drive with a pending completion. It returns a status byte that carries the drive number and a seek-ended flag, together with that drive's present cylinder, and it releases the drive's busy bit. If no drive has finished, the query answers with a fixed "invalid" byte. Issuing a data-access command abandons every head movement still under way.

Head stepping is modelled as counted clock cycles. No step pulses are produced.

Top module: `seek_tracker`

## Requirements
- R1: After reset every busy bit is 0, `rsp_valid` is 0 and every drive's present cylinder is 0.
- R2: A seek (`cmd_op`=0) or recalibrate (`cmd_op`=1) on drive d sets `busy[d]` on the clock edge that accepts it. The bit stays high until a sense query reports drive d or an access command cancels the movement.
- R3: While a drive is moving, its cylinder changes by exactly one toward the target once every STEP_SCALE*`step_rate`+1 cycles. After the cylinder equals the target, one further period passes and then the drive becomes pending. A seek to the present cylinder therefore completes after one period.
- R4: A recalibrate ignores `cmd_target` and steps down until cylinder 0, where it completes. The reported cylinder is 0.
- R5: An access command (`cmd_op`=3) returns every drive that is still moving to idle and clears its busy bit. Drives already pending keep their state.
- R6: A sense query (`cmd_op`=2) on the cycle after acceptance raises `rsp_valid` for one cycle with `rsp_hit`=1, `rsp_st0` = 0x20 OR drive number (bits 1:0 hold the drive), and `rsp_cyl` = that drive's cylinder. The drive's busy bit is cleared on the same edge.
- R7: When several drives are pending, the sense query reports the lowest-numbered one. The others stay pending for later queries.
- R8: A sense query with no pending drive answers `rsp_hit`=0 and `rsp_st0`=0x80.
- R9: A new seek on a drive that is already moving replaces its target and restarts its step period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | 0 seek, 1 recalibrate, 2 sense query, 3 access command |
| cmd_drive | input | 2 | Drive addressed by seek or recalibrate |
| cmd_target | input | 8 | Target cylinder for a seek |
| step_rate | input | 4 | Programmed step-rate value |
| busy | output | 4 | Per-drive busy bits of the main status byte |
| rsp_valid | output | 1 | Sense answer valid |
| rsp_hit | output | 1 | A completed drive was found |
| rsp_st0 | output | 8 | Status byte of the answer |
| rsp_cyl | output | 8 | Present cylinder of the reported drive |

## Verification
The hardest cases to reach are the collisions. In one, an access command lands while one drive is still moving and another has already finished. In the other, two or more drives finish before any query, so the reporting order matters. The stimulus issues seeks of different lengths and waits for the short ones to finish before issuing the cancelling command or the queries. A behavioural model in the bench follows every drive cycle by cycle and flags any divergence on the busy bits or the answers.

// File: rtl/seek_tracker.sv
module seek_tracker #(
  parameter int DRIVES = 4,
  parameter int STEP_SCALE = 8000,
  parameter int RATE_W = 4,
  parameter int CYL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [1:0]        cmd_drive,
  input  logic [CYL_W-1:0]  cmd_target,
  input  logic [RATE_W-1:0] step_rate,
  output logic [DRIVES-1:0] busy,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [7:0]        rsp_st0,
  output logic [CYL_W-1:0]  rsp_cyl
);
  localparam int CNT_W = $clog2(STEP_SCALE * ((1 << RATE_W) - 1) + 1) + 1;
  localparam logic [1:0] OP_SEEK = 2'd0, OP_RECAL = 2'd1, OP_SENSE = 2'd2, OP_ACCESS = 2'd3;
  localparam logic [1:0] PH_IDLE = 2'd0, PH_MOVE = 2'd1, PH_DONE = 2'd2;

  logic [1:0]       ph  [DRIVES];
  logic [CYL_W-1:0] cyl [DRIVES];
  logic [CYL_W-1:0] tgt [DRIVES];
  logic [CNT_W-1:0] cnt [DRIVES];
  logic [DRIVES-1:0] pend, sel;
  logic [CNT_W-1:0] period;
  logic [1:0] sel_idx;

  wire sense  = cmd_valid && cmd_op == OP_SENSE;
  wire access = cmd_valid && cmd_op == OP_ACCESS;
  wire start  = cmd_valid && (cmd_op == OP_SEEK || cmd_op == OP_RECAL);

  assign period = CNT_W'(STEP_SCALE) * CNT_W'(step_rate);

  always_comb begin
    sel = '0;
    sel_idx = '0;
    for (int i = DRIVES - 1; i >= 0; i--)
      if (pend[i]) begin
        sel = '0;
        sel[i] = 1'b1;
        sel_idx = 2'(i);
      end
  end

  for (genvar i = 0; i < DRIVES; i++) begin : g_drv
    assign pend[i] = ph[i] == PH_DONE;
    assign busy[i] = ph[i] != PH_IDLE;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ph[i] <= PH_IDLE;
        cyl[i] <= '0;
        tgt[i] <= '0;
        cnt[i] <= '0;
      end else if (start && cmd_drive == 2'(i)) begin
        ph[i] <= PH_MOVE;
        tgt[i] <= (cmd_op == OP_RECAL) ? '0 : cmd_target;
        cnt[i] <= period;
      end else if (access && ph[i] == PH_MOVE) begin
        ph[i] <= PH_IDLE;
      end else if (sense && sel[i]) begin
        ph[i] <= PH_IDLE;
      end else if (ph[i] == PH_MOVE) begin
        if (cnt[i] != '0) cnt[i] <= cnt[i] - 1'b1;
        else if (cyl[i] == tgt[i]) ph[i] <= PH_DONE;
        else begin
          cyl[i] <= (cyl[i] < tgt[i]) ? cyl[i] + 1'b1 : cyl[i] - 1'b1;
          cnt[i] <= period;
        end
      end
    end

    assert_start_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && cmd_drive == 2'(i)) |=> busy[i]);
    assert_access_cancels_R5: assert property (@(posedge clk) disable iff (!rst_n)
      access |=> ph[i] != PH_MOVE);
    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ph[i] == PH_MOVE |=> (cyl[i] == $past(cyl[i]) || cyl[i] == $past(cyl[i]) + 1'b1
                            || cyl[i] == $past(cyl[i]) - 1'b1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit <= 1'b0;
      rsp_st0 <= '0;
      rsp_cyl <= '0;
    end else begin
      rsp_valid <= sense;
      if (sense) begin
        rsp_hit <= |pend;
        rsp_st0 <= (|pend) ? {6'b001000, sel_idx} : 8'h80;
        rsp_cyl <= (|pend) ? cyl[sel_idx] : '0;
      end
    end
  end

  assert_rsp_from_query_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(sense));
  assert_reported_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> !busy[rsp_st0[1:0]]);
  assert_miss_only_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> $past(pend) == '0);
  assert_hit_is_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (($past(pend) & ((DRIVES'(1) << rsp_st0[1:0]) - 1'b1)) == '0));
endmodule

// File: tb/seek_tracker_test.sv
module seek_tracker_test;
  localparam int CLK_PERIOD = 10;
  localparam int SCALE = 3;
  localparam int LIMIT = 20000;

  logic clk = 0, rst_n = 0, cmd_valid = 0;
  logic [1:0] cmd_op = 0, cmd_drive = 0;
  logic [7:0] cmd_target = 0;
  logic [3:0] step_rate = 1;
  logic [3:0] busy;
  logic rsp_valid, rsp_hit;
  logic [7:0] rsp_st0, rsp_cyl;

  int checks = 0, failures = 0, cycles = 0;
  bit finished = 0;
  string cur_req = "R1";

  seek_tracker #(.STEP_SCALE(SCALE)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_drive(cmd_drive), .cmd_target(cmd_target), .step_rate(step_rate),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_st0(rsp_st0), .rsp_cyl(rsp_cyl));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural model: 0 idle, 1 moving, 2 finished
  int m_ph[4], m_cyl[4], m_tgt[4], m_cnt[4];
  bit m_rv, m_hit;
  int m_st0, m_rcyl;

  always @(posedge clk) begin
    int old[4];
    int found;
    if (!rst_n) begin
      foreach (m_ph[i]) begin m_ph[i] = 0; m_cyl[i] = 0; m_tgt[i] = 0; m_cnt[i] = 0; end
      m_rv = 0; m_hit = 0; m_st0 = 0; m_rcyl = 0;
    end else begin
      old = m_ph;
      found = -1;
      for (int i = 3; i >= 0; i--) if (old[i] == 2) found = i;
      for (int i = 0; i < 4; i++)
        if (old[i] == 1) begin
          if (m_cnt[i] > 0) m_cnt[i]--;
          else if (m_cyl[i] == m_tgt[i]) m_ph[i] = 2;
          else begin
            m_cyl[i] += (m_cyl[i] < m_tgt[i]) ? 1 : -1;
            m_cnt[i] = SCALE * step_rate;
          end
        end
      m_rv = cmd_valid && cmd_op == 2;
      if (m_rv) begin
        m_hit = found >= 0;
        m_st0 = (found >= 0) ? (32 + found) : 128;
        m_rcyl = (found >= 0) ? m_cyl[found] : 0;
        if (found >= 0) m_ph[found] = 0;
      end
      if (cmd_valid && cmd_op == 3)
        for (int i = 0; i < 4; i++) if (old[i] == 1) m_ph[i] = 0;
      if (cmd_valid && cmd_op <= 1) begin
        m_ph[cmd_drive] = 1;
        m_tgt[cmd_drive] = (cmd_op == 1) ? 0 : int'(cmd_target);
        m_cnt[cmd_drive] = SCALE * step_rate;
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    int mb;
    mb = 0;
    for (int i = 0; i < 4; i++) if (m_ph[i] != 0) mb |= 1 << i;
    check(cur_req, "busy", int'(busy), mb);
    check(cur_req, "rsp_valid", int'(rsp_valid), int'(m_rv));
    if (rsp_valid && m_rv) begin
      check(cur_req, "rsp_hit", int'(rsp_hit), int'(m_hit));
      check(cur_req, "rsp_st0", int'(rsp_st0), m_st0);
      if (m_hit) check(cur_req, "rsp_cyl", int'(rsp_cyl), m_rcyl);
    end
  end

  task automatic issue(input logic [1:0] op, input logic [1:0] d, input logic [7:0] t);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_drive = d; cmd_target = t;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic sense_expect(string req, bit hit, int st0, int cylv);
    issue(2'd2, 2'd0, 8'd0);
    check(req, "sense valid", int'(rsp_valid), 1);
    check(req, "sense hit", int'(rsp_hit), int'(hit));
    check(req, "sense st0", int'(rsp_st0), st0);
    if (hit) check(req, "sense cyl", int'(rsp_cyl), cylv);
  endtask

  task automatic wait_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "busy after reset", int'(busy), 0);
    check("R1", "rsp_valid after reset", int'(rsp_valid), 0);

    cur_req = "R8";
    sense_expect("R8", 0, 8'h80, 0);

    cur_req = "R2";
    issue(2'd0, 2'd1, 8'd3);
    check("R2", "busy[1] after seek", int'(busy[1]), 1);
    cur_req = "R3";
    // 3 steps + final period, each 4 cycles; 16 cycles needed, 1 already passed
    wait_cycles(14);
    sense_expect("R3", 0, 8'h80, 0);
    wait_cycles(2);
    cur_req = "R6";
    sense_expect("R6", 1, 8'h21, 3);
    check("R6", "busy cleared", int'(busy), 0);

    cur_req = "R7";
    issue(2'd0, 2'd2, 8'd5);
    issue(2'd0, 2'd0, 8'd2);
    wait_cycles(40);
    sense_expect("R7", 1, 8'h20, 2);
    check("R7", "drive 2 still pending", int'(busy), 4);
    sense_expect("R7", 1, 8'h22, 5);
    sense_expect("R8", 0, 8'h80, 0);

    cur_req = "R4";
    issue(2'd1, 2'd2, 8'd99);
    wait_cycles(40);
    sense_expect("R4", 1, 8'h22, 0);

    cur_req = "R5";
    issue(2'd0, 2'd0, 8'd0);
    issue(2'd0, 2'd3, 8'd50);
    wait_cycles(10);
    check("R5", "two busy before access", int'(busy), 9);
    issue(2'd3, 2'd0, 8'd0);
    check("R5", "moving drive cancelled, pending kept", int'(busy), 1);
    sense_expect("R5", 1, 8'h20, 0);
    sense_expect("R5", 0, 8'h80, 0);

    cur_req = "R9";
    issue(2'd0, 2'd1, 8'd10);
    wait_cycles(6);
    issue(2'd0, 2'd1, 8'd2);
    wait_cycles(40);
    sense_expect("R9", 1, 8'h21, 2);

    cur_req = "R3";
    step_rate = 0;
    issue(2'd0, 2'd3, 8'd7);
    wait_cycles(8);
    sense_expect("R3", 1, 8'h23, 7);
    step_rate = 1;
    issue(2'd0, 2'd0, 8'd0);
    wait_cycles(2);
    sense_expect("R3", 0, 8'h80, 0);
    wait_cycles(2);
    sense_expect("R3", 1, 8'h20, 0);

    wait_cycles(2);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule